// File: doc/BRIEF.md
# Segmented Real-Mode Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical address for a 1 MB space. It holds four segment registers: code, data, stack and extra. A write port loads them. It also holds a 16-bit stack pointer that software can load directly and that word-sized push and pop requests adjust.

Each request carries three things:
- an access kind: instruction fetch, data or stack;
- an optional segment override;
- for stack requests, an optional push or pop operation.

The block picks the segment that applies and places it four bits up. It adds the offset, or the stack pointer for push and pop, and registers the result. The result appears one cycle later with a valid strobe. A memory-side sequencer sits downstream and takes the address when the strobe is high.

Top module: `seg_addr_gen`

## Requirements
- R1: `addr_out` equals (segment × 16 + offset) truncated to 20 bits. A carry out of bit 19 is dropped, so FFFFh:FFFFh gives 0FFEFh.
- R2: With no override in effect, the default segment follows `req_kind`:
  - `req_kind` 0 (fetch) uses the code segment.
  - `req_kind` 1 (data) uses the data segment.
  - `req_kind` 2 (stack) uses the stack segment.
  - Code 3 is treated like data.
- R3: A data request with `req_ovr_en` high uses the segment named by `req_ovr_sel`. The same numbering also selects the target of `seg_wr_sel`: 0 code, 1 data, 2 stack, 3 extra.
- R4: An override on a fetch or stack request is ignored, and the default segment of R2 is used.
- R5: Distinct segment/offset pairs that name the same location yield the same address. A000h:5677h and A111h:4567h both give A5677h.
- R6: A stack request with `req_stk_op` 1 (push) lowers SP by 2 and forms its address from the lowered SP with the stack segment. `req_stk_op` acts only when `req_kind` is stack; on any other kind SP is unchanged and `req_offset` is used.
- R7: A stack request with `req_stk_op` 2 (pop) forms its address from the current SP with the stack segment, then raises SP by 2.
- R8: SP wraps modulo 65536. A push from 0000h leaves FFFEh, and a pop from FFFEh leaves 0000h.
- R9: `addr_valid` is high in exactly the cycle after each accepted request and low otherwise. `addr_out` holds its value while no request arrives.
- R10: A segment register written in the same cycle as a request keeps its old value for that request. The new value applies from the next request on.
- R11: An SP load in the same cycle as a push or pop wins over the adjustment, so SP takes the loaded value. The request's address still uses the SP held before the load.
- R12: After reset, all segment registers, SP and `addr_out` are zero and `addr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seg_wr_en | input | 1 | Load a segment register |
| seg_wr_sel | input | 2 | Segment to load (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | Value to load |
| sp_wr_en | input | 1 | Load the stack pointer |
| sp_wr_data | input | 16 | Stack pointer value to load |
| req_valid | input | 1 | Address request |
| req_kind | input | 2 | 0 fetch, 1 data, 2 stack |
| req_stk_op | input | 2 | 0 none, 1 push, 2 pop (stack kind only) |
| req_ovr_en | input | 1 | Segment override requested |
| req_ovr_sel | input | 2 | Override segment (data kind only) |
| req_offset | input | 16 | Offset for non push/pop requests |
| sp_value | output | 16 | Current stack pointer |
| addr_valid | output | 1 | `addr_out` carries a fresh address |
| addr_out | output | 20 | Physical address |

## Verification
Addresses are due exactly one clock edge after the request edge. Stack-pointer changes appear at that same edge and can be read on `sp_value` from the following falling edge. The driver queues each expected address as it presents a request. The monitor looks shortly after every rising edge: it pairs a high `addr_valid` with the head of the queue and flags both an unmatched strobe and a queued item that failed to appear. Same-cycle write cases (R10, R11) check the request against the old register contents, then check the written value on the next request or on `sp_value` one edge later.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam int NUM_SEG   = 4;
  localparam int SEG_IDX_W = $clog2(NUM_SEG);

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_DATA  = 2'd1,
    ACC_STACK = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [SEG_IDX_W-1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    STK_NONE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_RSVD = 2'd3
  } stk_op_e;

endpackage

// File: rtl/seg_bank.sv
// Segment register file: one register per segment, each with its own load enable.
module seg_bank
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEG_IDX_W-1:0]          wr_sel,
  input  logic [SEG_W-1:0]              wr_data,
  output logic [NUM_SEG-1:0][SEG_W-1:0] seg_q
);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic             hit;
    logic [SEG_W-1:0] seg_d;

    always_comb begin
      hit   = wr_en && (wr_sel == SEG_IDX_W'(g));
      seg_d = hit ? wr_data : seg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[g] <= '0;
      end else if (hit) begin
        seg_q[g] <= seg_d;
      end
    end
  end

endmodule

// File: rtl/seg_pick.sv
// Chooses the segment for a request: the default by kind, or the override on data accesses.
module seg_pick
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  acc_kind_e                     kind,
  input  logic                          ovr_en,
  input  seg_id_e                       ovr_sel,
  input  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q,
  output seg_id_e                       sel_idx,
  output logic [SEG_W-1:0]              seg_val
);

  seg_id_e dflt_idx;
  logic    ovr_ok;

  always_comb begin
    unique case (kind)
      ACC_FETCH: dflt_idx = SEG_CODE;
      ACC_STACK: dflt_idx = SEG_STACK;
      default:   dflt_idx = SEG_DATA;
    endcase
    ovr_ok  = ovr_en && (kind != ACC_FETCH) && (kind != ACC_STACK);
    sel_idx = ovr_ok ? ovr_sel : dflt_idx;
    seg_val = seg_q[sel_idx];
  end

endmodule

// File: rtl/sp_unit.sv
// Stack pointer: software load, pre-decrement push, post-increment pop.
module sp_unit
  import seg_addr_pkg::*;
#(
  parameter int OFF_W      = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stk_fire,
  input  stk_op_e          stk_op,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_data,
  output logic [OFF_W-1:0] sp_q,
  output logic [OFF_W-1:0] sp_addr,
  output logic             sp_used
);

  localparam logic [OFF_W-1:0] STEP = OFF_W'(WORD_BYTES);

  logic [OFF_W-1:0] sp_dec;
  logic [OFF_W-1:0] sp_inc;
  logic [OFF_W-1:0] sp_adj;
  logic [OFF_W-1:0] sp_d;
  logic             sp_en;

  always_comb begin
    sp_dec = sp_q - STEP;
    sp_inc = sp_q + STEP;
    unique case (stk_op)
      STK_PUSH: begin sp_addr = sp_dec; sp_adj = sp_dec; sp_used = 1'b1; end
      STK_POP:  begin sp_addr = sp_q;   sp_adj = sp_inc; sp_used = 1'b1; end
      default:  begin sp_addr = sp_q;   sp_adj = sp_q;   sp_used = 1'b0; end
    endcase
    sp_d  = wr_en ? wr_data : sp_adj;
    sp_en = wr_en || (stk_fire && sp_used);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

endmodule

// File: rtl/addr_stage.sv
// Shift-and-add of segment and offset, registered with a valid strobe.
module addr_stage #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  seg_val,
  input  logic [OFF_W-1:0]  offset,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_out
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    base    = {seg_val, {SHIFT{1'b0}}};
    off_ext = ADDR_W'(offset);
    addr_d  = base + off_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_out <= '0;
    end else if (req_valid) begin
      addr_out <= addr_d;
    end
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W      = 16,
  parameter int OFF_W      = 16,
  parameter int SHIFT      = 4,
  parameter int WORD_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seg_wr_en,
  input  logic [1:0]             seg_wr_sel,
  input  logic [SEG_W-1:0]       seg_wr_data,
  input  logic                   sp_wr_en,
  input  logic [OFF_W-1:0]       sp_wr_data,
  input  logic                   req_valid,
  input  logic [1:0]             req_kind,
  input  logic [1:0]             req_stk_op,
  input  logic                   req_ovr_en,
  input  logic [1:0]             req_ovr_sel,
  input  logic [OFF_W-1:0]       req_offset,
  output logic [OFF_W-1:0]       sp_value,
  output logic                   addr_valid,
  output logic [SEG_W+SHIFT-1:0] addr_out
);

  localparam int ADDR_W = SEG_W + SHIFT;

  logic [1:0] rst_pipe;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_sync = rst_pipe[1];

  acc_kind_e                     kind;
  stk_op_e                       op;
  seg_id_e                       sel_idx;
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  logic [SEG_W-1:0]              seg_val;
  logic [OFF_W-1:0]              sp_addr;
  logic                          sp_used;
  logic                          stk_fire;
  logic [OFF_W-1:0]              eff_off;

  always_comb begin
    kind     = acc_kind_e'(req_kind);
    op       = stk_op_e'(req_stk_op);
    stk_fire = req_valid && (kind == ACC_STACK);
    eff_off  = ((kind == ACC_STACK) && sp_used) ? sp_addr : req_offset;
  end

  seg_bank #(.SEG_W(SEG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (seg_wr_en),
    .wr_sel  (seg_wr_sel),
    .wr_data (seg_wr_data),
    .seg_q   (seg_q)
  );

  seg_pick #(.SEG_W(SEG_W)) u_pick (
    .kind    (kind),
    .ovr_en  (req_ovr_en),
    .ovr_sel (seg_id_e'(req_ovr_sel)),
    .seg_q   (seg_q),
    .sel_idx (sel_idx),
    .seg_val (seg_val)
  );

  sp_unit #(.OFF_W(OFF_W), .WORD_BYTES(WORD_BYTES)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .stk_fire (stk_fire),
    .stk_op   (op),
    .wr_en    (sp_wr_en),
    .wr_data  (sp_wr_data),
    .sp_q     (sp_value),
    .sp_addr  (sp_addr),
    .sp_used  (sp_used)
  );

  addr_stage #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .SHIFT  (SHIFT),
    .ADDR_W (ADDR_W)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .req_valid  (req_valid),
    .seg_val    (seg_val),
    .offset     (eff_off),
    .addr_valid (addr_valid),
    .addr_out   (addr_out)
  );

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
  import seg_addr_pkg::*;
#(
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [1:0]        req_stk_op,
  input logic [OFF_W-1:0]  req_offset,
  input logic              sp_wr_en,
  input logic [OFF_W-1:0]  sp_wr_data,
  input logic [OFF_W-1:0]  sp_value,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        sel_idx
);

  logic is_stack, is_push, is_pop, uses_sp;

  always_comb begin
    is_stack = req_kind == 2'd2;
    is_push  = is_stack && (req_stk_op == 2'd1);
    is_pop   = is_stack && (req_stk_op == 2'd2);
    uses_sp  = is_push || is_pop;
  end

  AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !uses_sp) |=> addr_out[SHIFT-1:0] == $past(req_offset[SHIFT-1:0])); // R1
  AST_FETCH_USES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |-> sel_idx == 2'd0); // R4
  AST_STACK_USES_SS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_stack) |-> sel_idx == 2'd2); // R4
  AST_PUSH_LOWERS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_push && !sp_wr_en) |=> sp_value == $past(sp_value) - 16'd2); // R6
  AST_POP_RAISES_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_pop && !sp_wr_en) |=> sp_value == $past(sp_value) + 16'd2); // R7
  AST_SP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_wr_en && !(req_valid && uses_sp)) |=> $stable(sp_value)); // R6
  AST_SP_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_en |=> sp_value == $past(sp_wr_data)); // R11
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid); // R9
  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(addr_out)); // R9

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .OFF_W  (OFF_W),
  .SHIFT  (SHIFT),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .req_stk_op (req_stk_op),
  .req_offset (req_offset),
  .sp_wr_en   (sp_wr_en),
  .sp_wr_data (sp_wr_data),
  .sp_value   (sp_value),
  .addr_valid (addr_valid),
  .addr_out   (addr_out),
  .sel_idx    (sel_idx)
);

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;

  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_wr_en;
  logic [1:0]  seg_wr_sel;
  logic [15:0] seg_wr_data;
  logic        sp_wr_en;
  logic [15:0] sp_wr_data;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [1:0]  req_stk_op;
  logic        req_ovr_en;
  logic [1:0]  req_ovr_sel;
  logic [15:0] req_offset;
  logic [15:0] sp_value;
  logic        addr_valid;
  logic [19:0] addr_out;

  always #(CLK_P/2) clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .req_stk_op(req_stk_op),
    .req_ovr_en(req_ovr_en), .req_ovr_sel(req_ovr_sel), .req_offset(req_offset),
    .sp_value(sp_value), .addr_valid(addr_valid), .addr_out(addr_out)
  );

  typedef struct {
    logic [19:0] addr;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  int          n_checks = 0;
  int          n_fail   = 0;
  logic [15:0] segm [4];
  logic [15:0] spm;
  logic [19:0] last_addr;
  bit          mon_on = 0;

  // same-cycle write side channels applied by the next issue()
  bit          pend_seg = 0;
  logic [1:0]  pend_seg_sel;
  logic [15:0] pend_seg_val;
  bit          pend_sp = 0;
  logic [15:0] pend_sp_val;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
    sp_wr_en = 0; sp_wr_data = 0;
    req_valid = 0; req_kind = 0; req_stk_op = 0;
    req_ovr_en = 0; req_ovr_sel = 0; req_offset = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clear_inputs();
    end
  endtask

  task automatic wr_seg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    clear_inputs();
    seg_wr_en = 1; seg_wr_sel = sel; seg_wr_data = val;
    segm[sel] = val;
  endtask

  task automatic wr_sp(input logic [15:0] val);
    @(negedge clk);
    clear_inputs();
    sp_wr_en = 1; sp_wr_data = val;
    spm = val;
  endtask

  task automatic issue(input logic [1:0] kind, input bit ovr_en, input logic [1:0] ovr_sel,
                       input logic [15:0] off, input logic [1:0] op, input string tag);
    logic [1:0]  idx;
    logic [15:0] eoff;
    exp_t        e;
    @(negedge clk);
    clear_inputs();
    req_valid = 1; req_kind = kind; req_ovr_en = ovr_en; req_ovr_sel = ovr_sel;
    req_offset = off; req_stk_op = op;
    if (kind == 2'd0)                  idx = 2'd0;
    else if (kind == 2'd2)             idx = 2'd2;
    else if (ovr_en)                   idx = ovr_sel;
    else                               idx = 2'd1;
    eoff = off;
    if (kind == 2'd2 && op == 2'd1) begin eoff = spm - 16'd2; spm = eoff; end
    else if (kind == 2'd2 && op == 2'd2) begin eoff = spm; spm = spm + 16'd2; end
    e.addr = {segm[idx], 4'h0} + {4'h0, eoff};
    e.tag  = tag;
    expq.push_back(e);
    if (pend_seg) begin
      seg_wr_en = 1; seg_wr_sel = pend_seg_sel; seg_wr_data = pend_seg_val;
      segm[pend_seg_sel] = pend_seg_val; pend_seg = 0;
    end
    if (pend_sp) begin
      sp_wr_en = 1; sp_wr_data = pend_sp_val; spm = pend_sp_val; pend_sp = 0;
    end
  endtask

  // monitor: results are due one rising edge after the request
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on) begin
        if (addr_valid) begin
          if (expq.size() == 0) begin
            check(0, "R9 unexpected valid", {12'h0, addr_out}, 32'h0);
          end else begin
            exp_t e;
            e = expq.pop_front();
            check(addr_out == e.addr, e.tag, {12'h0, addr_out}, {12'h0, e.addr});
            last_addr = e.addr;
          end
        end else if (expq.size() != 0) begin
          check(0, "R9 missing valid", 32'h0, 32'h1);
          void'(expq.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_inputs();
    for (int i = 0; i < 4; i++) segm[i] = 16'h0;
    spm = 16'h0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R12 reset state
    check(addr_valid == 0, "R12 valid after reset", {31'h0, addr_valid}, 32'h0);
    check(addr_out == 0, "R12 addr after reset", {12'h0, addr_out}, 32'h0);
    check(sp_value == 0, "R12 sp after reset", {16'h0, sp_value}, 32'h0);
    mon_on = 1;
    // R12 segments zero: data fetch at offset 0123 gives 00123
    issue(2'd1, 0, 2'd0, 16'h0123, 2'd0, "R12 zero segment");
    idle(1);

    wr_seg(2'd0, 16'h1234);
    wr_seg(2'd1, 16'hA000);
    wr_seg(2'd2, 16'h3000);
    wr_seg(2'd3, 16'hB800);
    idle(1);
    // R2 defaults, back to back
    issue(2'd0, 0, 2'd0, 16'h0010, 2'd0, "R2 fetch uses code");
    issue(2'd1, 0, 2'd0, 16'h5677, 2'd0, "R2 data uses data");
    issue(2'd2, 0, 2'd0, 16'h0100, 2'd0, "R2 stack uses stack");
    issue(2'd3, 0, 2'd0, 16'h0002, 2'd0, "R2 code 3 as data");
    // R3 override on data, all four
    for (int s = 0; s < 4; s++) issue(2'd1, 1, 2'(s), 16'h0004, 2'd0, "R3 data override");
    // R4 override ignored on fetch and stack
    issue(2'd0, 1, 2'd3, 16'h0020, 2'd0, "R4 fetch ignores override");
    issue(2'd2, 1, 2'd3, 16'h0030, 2'd0, "R4 stack ignores override");
    idle(2);
    // R9 address holds while idle
    check(addr_valid == 0, "R9 idle valid low", {31'h0, addr_valid}, 32'h0);
    check(addr_out == last_addr, "R9 addr holds", {12'h0, addr_out}, {12'h0, last_addr});
    // R5 aliasing
    wr_seg(2'd1, 16'hA111);
    issue(2'd1, 0, 2'd0, 16'h4567, 2'd0, "R5 alias A111:4567");
    // R1 wrap past 1 MB
    wr_seg(2'd1, 16'hFFFF);
    issue(2'd1, 0, 2'd0, 16'hFFFF, 2'd0, "R1 wrap FFFF:FFFF");
    idle(1);
    // R6 push / R7 pop
    wr_sp(16'h0100);
    issue(2'd2, 0, 2'd0, 16'h5555, 2'd1, "R6 push address");
    idle(1);
    check(sp_value == 16'h00FE, "R6 push sp", {16'h0, sp_value}, 32'h00FE);
    issue(2'd2, 0, 2'd0, 16'h5555, 2'd2, "R7 pop address");
    idle(1);
    check(sp_value == 16'h0100, "R7 pop sp", {16'h0, sp_value}, 32'h0100);
    // R6 push code on a data request: offset used, SP unchanged
    issue(2'd1, 0, 2'd0, 16'h0040, 2'd1, "R6 op ignored on data");
    idle(1);
    check(sp_value == 16'h0100, "R6 op ignored sp", {16'h0, sp_value}, 32'h0100);
    // R8 wrap of SP
    wr_sp(16'h0000);
    issue(2'd2, 0, 2'd0, 16'h0, 2'd1, "R8 push from 0 address");
    idle(1);
    check(sp_value == 16'hFFFE, "R8 push from 0 sp", {16'h0, sp_value}, 32'hFFFE);
    issue(2'd2, 0, 2'd0, 16'h0, 2'd2, "R8 pop to 0 address");
    idle(1);
    check(sp_value == 16'h0000, "R8 pop to 0 sp", {16'h0, sp_value}, 32'h0000);
    // R10 segment write in request cycle
    wr_seg(2'd1, 16'h1000);
    pend_seg = 1; pend_seg_sel = 2'd1; pend_seg_val = 16'h2000;
    issue(2'd1, 0, 2'd0, 16'h0008, 2'd0, "R10 old segment used");
    issue(2'd1, 0, 2'd0, 16'h0008, 2'd0, "R10 new segment next");
    // R11 SP load in push cycle
    wr_sp(16'h0100);
    pend_sp = 1; pend_sp_val = 16'h0500;
    issue(2'd2, 0, 2'd0, 16'h0, 2'd1, "R11 push uses old sp");
    idle(1);
    check(sp_value == 16'h0500, "R11 load wins", {16'h0, sp_value}, 32'h0500);
    idle(3);
    check(expq.size() == 0, "R9 queue drained", expq.size(), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule